// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block holds a small set of virtual-to-physical page translations and searches all of them in parallel. Each slot keeps a virtual page tag, a physical page number, an address space identifier, a global flag, read and write enable masks with one bit per privilege mode, two fault-on-access flags, and a valid flag. A lookup presents a virtual page and an address space identifier. In the same cycle, combinationally, the block returns whether a slot matched, which slot it was, and that slot's fields. Permission checking and page-table walks are left to the surrounding logic.

New translations go into the slot selected by a rotating replacement pointer. Any entry already in that slot is overwritten. The pointer's slot is also visible at all times on a separate set of outputs, and an index-read strobe can step the pointer on without writing anything. Three invalidation commands are provided. One empties the whole buffer. One drops every entry that is not global. One drops the entries that match a given page and address space. Exactly one command takes effect per cycle, chosen by a fixed priority. All state changes land on the clock edge, so a lookup made in the same cycle still sees the old contents.

Top module: `xlate_buf`

## Requirements
- R1: After a synchronous active-low reset, every slot is invalid, the replacement pointer is 0 and no lookup hits.
- R2: A lookup hits on a slot when the slot is valid, its tag equals `lk_vpn`, and either the slot's global flag is 1 or its stored identifier equals `lk_asn`.
- R3: On a hit, the `hit_*` field outputs carry the matching slot's contents. On a miss, `hit`, `hit_idx` and every field output are 0.
- R4: When more than one slot matches, the lowest-numbered slot is reported.
- R5: An insert writes all fields into the slot at the replacement pointer, overwriting any valid entry there, sets that slot valid, and advances the pointer by one.
- R6: The replacement pointer steps from ENTRIES-1 back to 0.
- R7: Flush-all invalidates every slot, clears its fields to 0, and sets the pointer to 0.
- R8: Flush-process invalidates every slot whose global flag is 0. Global slots and the pointer are unchanged.
- R9: Flush-page invalidates every valid slot whose tag equals `fl_vpn` and which is either global or holds the identifier `fl_asn`. Other slots and the pointer are unchanged.
- R10: The `vic_*` outputs always show the slot at the pointer. `idx_rd` together with `idx_adv` advances the pointer by one. `idx_rd` alone, or `idx_adv` alone, leaves the pointer unchanged.
- R11: Commands arriving in the same cycle are resolved in this priority order: flush-all, flush-process, flush-page, insert, index advance. Only the highest-priority command takes effect, and the rest are ignored in that cycle.
- R12: An insert or flush changes what a lookup returns only from the cycle after it is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_vpn | input | VPN_W | Virtual page number to look up |
| lk_asn | input | ASN_W | Address space identifier for the lookup |
| hit | output | 1 | A slot matched the lookup |
| hit_idx | output | IDX_W | Index of the matching slot |
| hit_ppn | output | PPN_W | Physical page number of the matching slot |
| hit_global | output | 1 | Global flag of the matching slot |
| hit_rd_en | output | MODES | Per-mode read enables of the matching slot |
| hit_wr_en | output | MODES | Per-mode write enables of the matching slot |
| hit_flt_rd | output | 1 | Fault-on-read flag of the matching slot |
| hit_flt_wr | output | 1 | Fault-on-write flag of the matching slot |
| ins_en | input | 1 | Insert strobe |
| ins_vpn | input | VPN_W | Tag to insert |
| ins_ppn | input | PPN_W | Physical page to insert |
| ins_asn | input | ASN_W | Identifier to insert |
| ins_global | input | 1 | Global flag to insert |
| ins_rd_en | input | MODES | Read enables to insert |
| ins_wr_en | input | MODES | Write enables to insert |
| ins_flt_rd | input | 1 | Fault-on-read flag to insert |
| ins_flt_wr | input | 1 | Fault-on-write flag to insert |
| flush_all | input | 1 | Invalidate all slots |
| flush_proc | input | 1 | Invalidate all non-global slots |
| flush_page | input | 1 | Invalidate slots matching fl_vpn/fl_asn |
| fl_vpn | input | VPN_W | Page for flush-page |
| fl_asn | input | ASN_W | Identifier for flush-page |
| idx_rd | input | 1 | Index-read strobe |
| idx_adv | input | 1 | Advance the pointer with an index read |
| vic_ptr | output | IDX_W | Current replacement pointer |
| vic_valid | output | 1 | Valid flag of the slot at the pointer |
| vic_vpn | output | VPN_W | Tag of the slot at the pointer |
| vic_ppn | output | PPN_W | Physical page of the slot at the pointer |
| vic_asn | output | ASN_W | Identifier of the slot at the pointer |
| vic_global | output | 1 | Global flag of the slot at the pointer |

## Verification
The bench builds the buffer with four slots, 8-bit tags and 4-bit identifiers. Four slots let a handful of inserts reach the pointer wrap and the overwriting of a live entry. In the random phase, tags are drawn from only eight values, which makes duplicate tags, several slots matching at once, and global/non-global collisions on one page frequent. These conditions exercise the lowest-index selection and the selective flushes. The random phase also raises several commands in the same cycle, which tests the priority order against the reference model.

// File: rtl/xb_pkg.sv
// Shared definitions for the translation buffer: the single command that
// wins arbitration in a cycle. Assumes at most one state change per cycle.
package xb_pkg;
    typedef enum logic [2:0] {
        OP_NONE       = 3'd0,
        OP_FLUSH_ALL  = 3'd1,
        OP_FLUSH_PROC = 3'd2,
        OP_FLUSH_PAGE = 3'd3,
        OP_INSERT     = 3'd4,
        OP_ADVANCE    = 3'd5
    } xb_op_e;
endpackage

// File: rtl/xb_cmd_dec.sv
// Command arbiter: reduces the command strobes to one operation using the
// fixed priority flush-all > flush-process > flush-page > insert > advance.
// Assumes the strobes are synchronous to the buffer clock.
module xb_cmd_dec
    import xb_pkg::*;
(
    input  logic   flush_all,
    input  logic   flush_proc,
    input  logic   flush_page,
    input  logic   ins_en,
    input  logic   idx_rd,
    input  logic   idx_adv,
    output xb_op_e op
);
    // Priority selection of the winning command
    always_comb begin
        if (flush_all)               op = OP_FLUSH_ALL;
        else if (flush_proc)         op = OP_FLUSH_PROC;
        else if (flush_page)         op = OP_FLUSH_PAGE;
        else if (ins_en)             op = OP_INSERT;
        else if (idx_rd && idx_adv)  op = OP_ADVANCE;
        else                         op = OP_NONE;
    end
endmodule

// File: rtl/xb_victim.sv
// Replacement pointer: steps on insert and index advance, wraps from the
// last slot to zero, and returns to zero on flush-all or reset.
// Assumes ENTRIES >= 1 and that op is already arbitrated.
module xb_victim
    import xb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  xb_op_e           op,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    // Pointer register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else begin
            case (op)
                OP_FLUSH_ALL:         ptr <= '0;
                OP_INSERT, OP_ADVANCE: ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
                default:              ptr <= ptr;
            endcase
        end
    end
endmodule

// File: rtl/xb_entry.sv
// One translation slot: storage for all fields, lookup compare and
// flush-page compare. Writes only when selected by the pointer on insert.
// Assumes op is already arbitrated so only one update applies per cycle.
module xb_entry
    import xb_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int PPN_W = 16,
    parameter int ASN_W = 8,
    parameter int MODES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  xb_op_e           op,
    input  logic             sel,
    input  logic [VPN_W-1:0] w_vpn,
    input  logic [PPN_W-1:0] w_ppn,
    input  logic [ASN_W-1:0] w_asn,
    input  logic             w_glob,
    input  logic [MODES-1:0] w_rd_en,
    input  logic [MODES-1:0] w_wr_en,
    input  logic             w_flt_rd,
    input  logic             w_flt_wr,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [ASN_W-1:0] lk_asn,
    input  logic [VPN_W-1:0] fl_vpn,
    input  logic [ASN_W-1:0] fl_asn,
    output logic             valid,
    output logic [VPN_W-1:0] vpn,
    output logic [PPN_W-1:0] ppn,
    output logic [ASN_W-1:0] asn,
    output logic             glob,
    output logic [MODES-1:0] rd_en,
    output logic [MODES-1:0] wr_en,
    output logic             flt_rd,
    output logic             flt_wr,
    output logic             lk_match
);
    logic fl_match;

    // Lookup compare: tag plus identifier unless global
    always_comb lk_match = valid && (vpn == lk_vpn) && (glob || (asn == lk_asn));

    // Flush-page compare with the same matching rule
    always_comb fl_match = valid && (vpn == fl_vpn) && (glob || (asn == fl_asn));

    // Slot storage update
    always_ff @(posedge clk) begin
        if (!rst_n || op == OP_FLUSH_ALL) begin
            valid  <= 1'b0;
            vpn    <= '0;
            ppn    <= '0;
            asn    <= '0;
            glob   <= 1'b0;
            rd_en  <= '0;
            wr_en  <= '0;
            flt_rd <= 1'b0;
            flt_wr <= 1'b0;
        end else begin
            case (op)
                OP_FLUSH_PROC: if (!glob) valid <= 1'b0;
                OP_FLUSH_PAGE: if (fl_match) valid <= 1'b0;
                OP_INSERT: if (sel) begin
                    valid  <= 1'b1;
                    vpn    <= w_vpn;
                    ppn    <= w_ppn;
                    asn    <= w_asn;
                    glob   <= w_glob;
                    rd_en  <= w_rd_en;
                    wr_en  <= w_wr_en;
                    flt_rd <= w_flt_rd;
                    flt_wr <= w_flt_wr;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/xb_prio_enc.sv
// Lowest-index priority encoder over the slot match vector.
// Assumes N >= 1; idx is 0 when nothing is requested.
module xb_prio_enc #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so the lowest set bit wins
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
        any = |req;
    end
endmodule

// File: rtl/xlate_buf.sv
// Fully associative translation buffer top. Instantiates the slots, the
// command arbiter, the replacement pointer and the hit encoder, and muxes
// out the hit slot and the pointer slot. Lookup is combinational; all
// updates land on the clock edge. Assumes a single clock domain.
module xlate_buf
    import xb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 16,
    parameter int ASN_W   = 8,
    parameter int MODES   = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [ASN_W-1:0] lk_asn,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic [PPN_W-1:0] hit_ppn,
    output logic             hit_global,
    output logic [MODES-1:0] hit_rd_en,
    output logic [MODES-1:0] hit_wr_en,
    output logic             hit_flt_rd,
    output logic             hit_flt_wr,
    input  logic             ins_en,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [PPN_W-1:0] ins_ppn,
    input  logic [ASN_W-1:0] ins_asn,
    input  logic             ins_global,
    input  logic [MODES-1:0] ins_rd_en,
    input  logic [MODES-1:0] ins_wr_en,
    input  logic             ins_flt_rd,
    input  logic             ins_flt_wr,
    input  logic             flush_all,
    input  logic             flush_proc,
    input  logic             flush_page,
    input  logic [VPN_W-1:0] fl_vpn,
    input  logic [ASN_W-1:0] fl_asn,
    input  logic             idx_rd,
    input  logic             idx_adv,
    output logic [IDX_W-1:0] vic_ptr,
    output logic             vic_valid,
    output logic [VPN_W-1:0] vic_vpn,
    output logic [PPN_W-1:0] vic_ppn,
    output logic [ASN_W-1:0] vic_asn,
    output logic             vic_global
);
    xb_op_e               op;
    logic [ENTRIES-1:0]   valid_vec;
    logic [ENTRIES-1:0]   glob_vec;
    logic [ENTRIES-1:0]   match_vec;
    logic [ENTRIES-1:0]   flrd_vec;
    logic [ENTRIES-1:0]   flwr_vec;
    logic [VPN_W-1:0]     vpn_arr   [ENTRIES];
    logic [PPN_W-1:0]     ppn_arr   [ENTRIES];
    logic [ASN_W-1:0]     asn_arr   [ENTRIES];
    logic [MODES-1:0]     rden_arr  [ENTRIES];
    logic [MODES-1:0]     wren_arr  [ENTRIES];
    logic                 any_match;
    logic [IDX_W-1:0]     enc_idx;

    xb_cmd_dec u_dec (
        .flush_all (flush_all),
        .flush_proc(flush_proc),
        .flush_page(flush_page),
        .ins_en    (ins_en),
        .idx_rd    (idx_rd),
        .idx_adv   (idx_adv),
        .op        (op)
    );

    xb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_vic (
        .clk  (clk),
        .rst_n(rst_n),
        .op   (op),
        .ptr  (vic_ptr)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        xb_entry #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ASN_W(ASN_W), .MODES(MODES)) u_ent (
            .clk     (clk),
            .rst_n   (rst_n),
            .op      (op),
            .sel     (vic_ptr == IDX_W'(g)),
            .w_vpn   (ins_vpn),
            .w_ppn   (ins_ppn),
            .w_asn   (ins_asn),
            .w_glob  (ins_global),
            .w_rd_en (ins_rd_en),
            .w_wr_en (ins_wr_en),
            .w_flt_rd(ins_flt_rd),
            .w_flt_wr(ins_flt_wr),
            .lk_vpn  (lk_vpn),
            .lk_asn  (lk_asn),
            .fl_vpn  (fl_vpn),
            .fl_asn  (fl_asn),
            .valid   (valid_vec[g]),
            .vpn     (vpn_arr[g]),
            .ppn     (ppn_arr[g]),
            .asn     (asn_arr[g]),
            .glob    (glob_vec[g]),
            .rd_en   (rden_arr[g]),
            .wr_en   (wren_arr[g]),
            .flt_rd  (flrd_vec[g]),
            .flt_wr  (flwr_vec[g]),
            .lk_match(match_vec[g])
        );
    end

    xb_prio_enc #(.N(ENTRIES), .IDX_W(IDX_W)) u_enc (
        .req(match_vec),
        .any(any_match),
        .idx(enc_idx)
    );

    // Hit result mux, forced to zero on a miss
    always_comb begin
        hit        = any_match;
        hit_idx    = any_match ? enc_idx : '0;
        hit_ppn    = any_match ? ppn_arr[enc_idx]  : '0;
        hit_global = any_match ? glob_vec[enc_idx] : 1'b0;
        hit_rd_en  = any_match ? rden_arr[enc_idx] : '0;
        hit_wr_en  = any_match ? wren_arr[enc_idx] : '0;
        hit_flt_rd = any_match ? flrd_vec[enc_idx] : 1'b0;
        hit_flt_wr = any_match ? flwr_vec[enc_idx] : 1'b0;
    end

    // Slot-at-pointer mux for the index-read view
    always_comb begin
        vic_valid  = valid_vec[vic_ptr];
        vic_vpn    = vpn_arr[vic_ptr];
        vic_ppn    = ppn_arr[vic_ptr];
        vic_asn    = asn_arr[vic_ptr];
        vic_global = glob_vec[vic_ptr];
    end
endmodule

// File: rtl/xb_checker.sv
// Property checker for the translation buffer, attached by bind.
module xb_checker
    import xb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input xb_op_e             op,
    input logic [IDX_W-1:0]   vic_ptr,
    input logic [ENTRIES-1:0] valid_vec,
    input logic [ENTRIES-1:0] glob_vec,
    input logic [ENTRIES-1:0] match_vec,
    input logic               hit,
    input logic [IDX_W-1:0]   hit_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);
    logic [ENTRIES-1:0] below_mask;

    // Mask of slots below the reported hit
    always_comb below_mask = (ENTRIES'(1) << hit_idx) - ENTRIES'(1);

    // R5 R6
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INSERT || op == OP_ADVANCE) |=>
            vic_ptr == (($past(vic_ptr) == LAST) ? '0 : $past(vic_ptr) + 1'b1));

    // R5
    ins_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INSERT) |=> valid_vec[$past(vic_ptr)]);

    // R7
    flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_FLUSH_ALL) |=> (valid_vec == '0) && (vic_ptr == '0));

    // R8
    flush_proc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_FLUSH_PROC) |=> ((valid_vec & ~glob_vec) == '0) && $stable(vic_ptr));

    // R2
    hit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> valid_vec[hit_idx] && match_vec[hit_idx]);

    // R4
    lowest_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (match_vec & below_mask) == '0);

    // R10
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NONE) |=> $stable(vic_ptr) && $stable(valid_vec));
endmodule

bind xlate_buf xb_checker #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .vic_ptr  (vic_ptr),
    .valid_vec(valid_vec),
    .glob_vec (glob_vec),
    .match_vec(match_vec),
    .hit      (hit),
    .hit_idx  (hit_idx)
);

// File: tb/test_xlate_buf.sv
`timescale 1ns/1ps
module test_xlate_buf;
    localparam int E = 4, VW = 8, PW = 12, AW = 4, MW = 4, IW = 2;

    logic clk = 0, rst_n = 0;
    logic [VW-1:0] lk_vpn = 0, ins_vpn = 0, fl_vpn = 0;
    logic [AW-1:0] lk_asn = 0, ins_asn = 0, fl_asn = 0;
    logic [PW-1:0] ins_ppn = 0;
    logic [MW-1:0] ins_rd_en = 0, ins_wr_en = 0;
    logic ins_en = 0, ins_global = 0, ins_flt_rd = 0, ins_flt_wr = 0;
    logic flush_all = 0, flush_proc = 0, flush_page = 0, idx_rd = 0, idx_adv = 0;
    logic hit, hit_global, hit_flt_rd, hit_flt_wr, vic_valid, vic_global;
    logic [IW-1:0] hit_idx, vic_ptr;
    logic [PW-1:0] hit_ppn, vic_ppn;
    logic [MW-1:0] hit_rd_en, hit_wr_en;
    logic [VW-1:0] vic_vpn;
    logic [AW-1:0] vic_asn;

    int total = 0, bad = 0;
    bit done = 0;

    xlate_buf #(.ENTRIES(E), .VPN_W(VW), .PPN_W(PW), .ASN_W(AW), .MODES(MW)) i_xlate_buf (
        .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_asn(lk_asn),
        .hit(hit), .hit_idx(hit_idx), .hit_ppn(hit_ppn), .hit_global(hit_global),
        .hit_rd_en(hit_rd_en), .hit_wr_en(hit_wr_en), .hit_flt_rd(hit_flt_rd),
        .hit_flt_wr(hit_flt_wr), .ins_en(ins_en), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn),
        .ins_asn(ins_asn), .ins_global(ins_global), .ins_rd_en(ins_rd_en),
        .ins_wr_en(ins_wr_en), .ins_flt_rd(ins_flt_rd), .ins_flt_wr(ins_flt_wr),
        .flush_all(flush_all), .flush_proc(flush_proc), .flush_page(flush_page),
        .fl_vpn(fl_vpn), .fl_asn(fl_asn), .idx_rd(idx_rd), .idx_adv(idx_adv),
        .vic_ptr(vic_ptr), .vic_valid(vic_valid), .vic_vpn(vic_vpn), .vic_ppn(vic_ppn),
        .vic_asn(vic_asn), .vic_global(vic_global)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    bit            m_v  [E];
    bit [VW-1:0]   m_vpn[E];
    bit [PW-1:0]   m_ppn[E];
    bit [AW-1:0]   m_asn[E];
    bit            m_g  [E];
    int            m_ptr = 0;

    always @(posedge clk) begin
        if (!rst_n || flush_all) begin
            for (int i = 0; i < E; i++) begin
                m_v[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0; m_asn[i] = 0; m_g[i] = 0;
            end
            m_ptr = 0;
        end else if (flush_proc) begin
            for (int i = 0; i < E; i++) if (!m_g[i]) m_v[i] = 0;
        end else if (flush_page) begin
            for (int i = 0; i < E; i++)
                if (m_v[i] && m_vpn[i] == fl_vpn && (m_g[i] || m_asn[i] == fl_asn)) m_v[i] = 0;
        end else if (ins_en) begin
            m_v[m_ptr] = 1; m_vpn[m_ptr] = ins_vpn; m_ppn[m_ptr] = ins_ppn;
            m_asn[m_ptr] = ins_asn; m_g[m_ptr] = ins_global;
            m_ptr = (m_ptr + 1) % E;
        end else if (idx_rd && idx_adv) begin
            m_ptr = (m_ptr + 1) % E;
        end
    end

    // Per-cycle comparison against the model
    bit e_hit; int e_idx;
    always @(negedge clk) begin
        if (rst_n) begin
            e_hit = 0; e_idx = 0;
            for (int i = E - 1; i >= 0; i--)
                if (m_v[i] && m_vpn[i] == lk_vpn && (m_g[i] || m_asn[i] == lk_asn)) begin
                    e_hit = 1; e_idx = i;
                end
            chk("R2 model hit", 64'(hit), 64'(e_hit));
            chk("R4 model index", 64'(hit_idx), 64'(e_idx));
            chk("R3 model ppn", 64'(hit_ppn), e_hit ? 64'(m_ppn[e_idx]) : 64'd0);
            chk("R3 model global", 64'(hit_global), e_hit ? 64'(m_g[e_idx]) : 64'd0);
            chk("R10 model pointer", 64'(vic_ptr), 64'(m_ptr));
            chk("R10 model victim valid", 64'(vic_valid), 64'(m_v[m_ptr]));
            chk("R10 model victim tag", 64'(vic_vpn), 64'(m_vpn[m_ptr]));
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic ins(input [VW-1:0] v, input [PW-1:0] p, input [AW-1:0] a, input bit g,
                       input [MW-1:0] rd, input [MW-1:0] wr, input bit fr, input bit fw);
        ins_vpn = v; ins_ppn = p; ins_asn = a; ins_global = g;
        ins_rd_en = rd; ins_wr_en = wr; ins_flt_rd = fr; ins_flt_wr = fw;
        ins_en = 1; step(); ins_en = 0;
    endtask

    task automatic fpage(input [VW-1:0] v, input [AW-1:0] a);
        fl_vpn = v; fl_asn = a; flush_page = 1; step(); flush_page = 0;
    endtask

    task automatic look(input [VW-1:0] v, input [AW-1:0] a);
        lk_vpn = v; lk_asn = a; @(negedge clk);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R1 reset hit", 64'(hit), 0);
        chk("R1 reset pointer", 64'(vic_ptr), 0);
        chk("R1 reset valid", 64'(vic_valid), 0);
        step();

        ins(8'd5, 12'h011, 4'd3, 0, 4'b0011, 4'b0001, 1, 0);    // slot 0
        look(8'd5, 4'd3);
        chk("R2 hit same id", 64'(hit), 1);
        chk("R3 ppn", 64'(hit_ppn), 64'h011);
        chk("R3 rd_en", 64'(hit_rd_en), 64'b0011);
        chk("R3 wr_en", 64'(hit_wr_en), 64'b0001);
        chk("R3 flt_rd", 64'(hit_flt_rd), 1);
        look(8'd5, 4'd4);
        chk("R2 miss other id", 64'(hit), 0);
        chk("R3 miss ppn zero", 64'(hit_ppn), 0);
        step();

        ins(8'd6, 12'h022, 4'd1, 1, 4'b1111, 4'b1111, 0, 1);    // slot 1 global
        look(8'd6, 4'd9);
        chk("R2 global any id", 64'(hit), 1);
        chk("R2 global index", 64'(hit_idx), 1);
        step();

        ins(8'd5, 12'h033, 4'd3, 0, 4'b0001, 4'b0001, 0, 0);    // slot 2 duplicate
        look(8'd5, 4'd3);
        chk("R4 lowest index", 64'(hit_idx), 0);
        chk("R4 lowest ppn", 64'(hit_ppn), 64'h011);
        step();

        // R12: insert slot 3 with lookup in the same cycle
        lk_vpn = 8'd7; lk_asn = 4'd2;
        ins_vpn = 8'd7; ins_ppn = 12'h044; ins_asn = 4'd2; ins_global = 0;
        ins_en = 1;
        @(negedge clk);
        chk("R12 same cycle miss", 64'(hit), 0);
        step(); ins_en = 0;
        @(negedge clk);
        chk("R12 next cycle hit", 64'(hit), 1);
        chk("R12 next cycle index", 64'(hit_idx), 3);
        chk("R6 pointer wrap", 64'(vic_ptr), 0);
        chk("R10 view tag", 64'(vic_vpn), 5);
        step();

        idx_rd = 1; idx_adv = 0; step(); idx_rd = 0;
        @(negedge clk);
        chk("R10 read without advance", 64'(vic_ptr), 0);
        step();
        idx_adv = 1; step(); idx_adv = 0;
        @(negedge clk);
        chk("R10 advance without read", 64'(vic_ptr), 0);
        step();
        idx_rd = 1; idx_adv = 1; step(); idx_rd = 0; idx_adv = 0;
        @(negedge clk);
        chk("R10 read with advance", 64'(vic_ptr), 1);
        chk("R10 view global", 64'(vic_global), 1);
        step();

        ins(8'd9, 12'h055, 4'd3, 0, 4'b0001, 4'b0001, 0, 0);    // overwrites slot 1
        look(8'd6, 4'd9);
        chk("R5 overwritten entry gone", 64'(hit), 0);
        look(8'd9, 4'd3);
        chk("R5 new entry index", 64'(hit_idx), 1);
        chk("R5 new entry ppn", 64'(hit_ppn), 64'h055);
        chk("R5 pointer advanced", 64'(vic_ptr), 2);
        step();

        fpage(8'd5, 4'd3);
        look(8'd5, 4'd3);
        chk("R9 page removed", 64'(hit), 0);
        look(8'd9, 4'd3);
        chk("R9 other page kept", 64'(hit), 1);
        chk("R9 pointer kept", 64'(vic_ptr), 2);
        step();

        ins(8'd8, 12'h066, 4'd0, 1, 4'b0001, 4'b0001, 0, 0);    // slot 2 global
        flush_proc = 1; step(); flush_proc = 0;
        look(8'd8, 4'd5);
        chk("R8 global kept", 64'(hit), 1);
        chk("R8 global index", 64'(hit_idx), 2);
        look(8'd7, 4'd2);
        chk("R8 non-global removed", 64'(hit), 0);
        chk("R8 pointer kept", 64'(vic_ptr), 3);
        step();

        // R11: flush-page beats insert
        fl_vpn = 8'd8; fl_asn = 4'd7; flush_page = 1;
        ins_vpn = 8'd10; ins_asn = 4'd1; ins_global = 0; ins_en = 1;
        step(); flush_page = 0; ins_en = 0;
        look(8'd10, 4'd1);
        chk("R11 insert ignored", 64'(hit), 0);
        chk("R11 pointer unmoved", 64'(vic_ptr), 3);
        look(8'd8, 4'd7);
        chk("R9 global page removed", 64'(hit), 0);
        step();

        ins(8'd12, 12'h077, 4'd1, 0, 4'b0001, 4'b0001, 0, 0);   // slot 3
        ins(8'd13, 12'h088, 4'd1, 0, 4'b0001, 4'b0001, 0, 0);   // slot 0
        flush_all = 1; ins_vpn = 8'd11; ins_en = 1;
        step(); flush_all = 0; ins_en = 0;
        look(8'd12, 4'd1);
        chk("R7 entries cleared", 64'(hit), 0);
        chk("R7 pointer zero", 64'(vic_ptr), 0);
        chk("R7 fields zero", 64'(vic_vpn), 0);
        look(8'd11, 4'd0);
        chk("R11 flush-all beats insert", 64'(hit), 0);
        step();

        // Random phase compared against the model every cycle
        for (int n = 0; n < 600; n++) begin
            lk_vpn = VW'($urandom_range(0, 7)); lk_asn = AW'($urandom_range(0, 3));
            ins_vpn = VW'($urandom_range(0, 7)); ins_asn = AW'($urandom_range(0, 3));
            ins_ppn = PW'($urandom); ins_global = ($urandom_range(0, 3) == 0);
            fl_vpn = VW'($urandom_range(0, 7)); fl_asn = AW'($urandom_range(0, 3));
            ins_en = ($urandom_range(0, 2) == 0);
            flush_all = ($urandom_range(0, 30) == 0);
            flush_proc = ($urandom_range(0, 15) == 0);
            flush_page = ($urandom_range(0, 6) == 0);
            idx_rd = ($urandom_range(0, 3) == 0); idx_adv = ($urandom_range(0, 1) == 0);
            step();
        end
        ins_en = 0; flush_all = 0; flush_proc = 0; flush_page = 0; idx_rd = 0; idx_adv = 0;
        step();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule